// File: doc/BRIEF.md
# Load/Store Execution Unit

This unit executes the memory instructions of a 32-bit big-endian RISC core. When an instruction word arrives with its valid strobe and the unit is idle, it decodes the major opcode and computes the effective address as the base register value plus a sign-extended 16-bit offset. It then presents one request on a simple data-memory port with a byte address, byte-lane enables, steered write data and a write flag. The request is held until memory signals ready. Loads narrow and extend the returned word according to the opcode and hand the result to the register file. Stores write the selected lanes only.

Opcodes outside the unit's set raise a one-cycle illegal-instruction flag. Accesses that are not naturally aligned raise a one-cycle alignment flag. In both cases no memory access is made. The load-linked and store-conditional opcodes behave as plain word accesses here. They are marked on a separate output so that a neighbouring reservation block can act on them.

Top module: `lsu_core`

## Requirements
- R1: Loads use major opcode bits 31:26 with codes 0x21 (word), 0x22 (word, signed), 0x23 (byte, zero-extended), 0x24 (byte, sign-extended), 0x25 (half, zero-extended), 0x26 (half, sign-extended) and 0x1B (linked word). The destination is taken from bits 25:21 and the base register value comes from `ra_val`. The address is `ra_val` plus the sign-extended bits 15:0.
- R2: Stores use codes 0x35 (word), 0x36 (byte), 0x37 (half) and 0x33 (conditional word), with data taken from `rb_val`. The signed 16-bit offset is assembled as {bits 25:21, bits 10:0} and added to `ra_val`.
- R3: Memory is big-endian, and address offset 0 maps to data bits 31:24 and enable bit 3. A byte store drives one enable and replicates the byte on all four lanes. A half store drives enables 3:2 or 1:0 and replicates the half on both halves. A word store drives all four enables with `rb_val`. Loads drive the enables of the lanes they read.
- R4: Byte and half loads take the lanes selected by the address, then zero-extend or sign-extend them to 32 bits as the opcode selects. Word loads return the full word.
- R5: `mem_excl` is high during accesses made by opcode 0x1B or 0x33, and low for all other accesses.
- R6: A load whose destination field is 0 completes its memory access but never asserts `wb_en`.
- R7: An unrecognised opcode pulses `fault_illegal` for one cycle after the instruction edge, and no memory request is made.
- R8: A half access at an odd address, or a word access whose low two address bits are not both zero, pulses `fault_align` for one cycle and makes no memory request.
- R9: `mem_req` rises on the cycle after an accepted instruction. Address, enables and data stay stable until `mem_ready` is sampled high, and the request drops on the next cycle. A load then asserts `wb_en` for exactly that one cycle, with `wb_idx` and `wb_data`.
- R10: While `busy` is high, `instr_valid` is ignored and raises no fault.
- R11: After reset, `busy`, `mem_req`, `mem_we`, `wb_en` and both fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Store data register value |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the pending request |
| busy | output | 1 | Access in progress; new instructions ignored |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Pending request is a write |
| mem_excl | output | 1 | Pending request comes from a linked/conditional opcode |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-steered write data |
| wb_en | output | 1 | One-cycle register write-back strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |
| fault_illegal | output | 1 | One-cycle illegal opcode pulse |
| fault_align | output | 1 | One-cycle misaligned access pulse |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, 5-bit register indices and the alignment check enabled. The alignment check being on is what brings the fault path of R8 within reach; with it off, misaligned addresses would be forced to natural alignment instead. Random memory latencies of zero to three cycles exercise request holding. An instruction poked into the busy window reaches the R10 path.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam logic [5:0] OPC_LD_WZ  = 6'h21;
   localparam logic [5:0] OPC_LD_WS  = 6'h22;
   localparam logic [5:0] OPC_LD_BZ  = 6'h23;
   localparam logic [5:0] OPC_LD_BS  = 6'h24;
   localparam logic [5:0] OPC_LD_HZ  = 6'h25;
   localparam logic [5:0] OPC_LD_HS  = 6'h26;
   localparam logic [5:0] OPC_LD_LNK = 6'h1B;
   localparam logic [5:0] OPC_ST_W   = 6'h35;
   localparam logic [5:0] OPC_ST_B   = 6'h36;
   localparam logic [5:0] OPC_ST_H   = 6'h37;
   localparam logic [5:0] OPC_ST_CND = 6'h33;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic       known;
      logic       is_load;
      logic       is_store;
      logic       excl;
      logic       sext;
      acc_size_e  size;
      logic [4:0] dst;
      logic [15:0] ofs;
   } dec_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);
   logic [5:0] opc;
   assign opc = instr[31:26];

   always_comb begin
      dec          = '0;
      dec.size     = SZ_WORD;
      dec.dst      = instr[25:21];
      dec.ofs      = instr[15:0];
      unique case (opc)
         OPC_LD_WZ, OPC_LD_WS, OPC_LD_LNK: begin
            dec.known   = 1'b1;
            dec.is_load = 1'b1;
            dec.excl    = (opc == OPC_LD_LNK);
         end
         OPC_LD_BZ, OPC_LD_BS: begin
            dec.known   = 1'b1;
            dec.is_load = 1'b1;
            dec.size    = SZ_BYTE;
            dec.sext    = (opc == OPC_LD_BS);
         end
         OPC_LD_HZ, OPC_LD_HS: begin
            dec.known   = 1'b1;
            dec.is_load = 1'b1;
            dec.size    = SZ_HALF;
            dec.sext    = (opc == OPC_LD_HS);
         end
         OPC_ST_W, OPC_ST_B, OPC_ST_H, OPC_ST_CND: begin
            dec.known    = 1'b1;
            dec.is_store = 1'b1;
            dec.dst      = '0;
            dec.ofs      = {instr[25:21], instr[10:0]};
            dec.excl     = (opc == OPC_ST_CND);
            dec.size     = (opc == OPC_ST_B) ? SZ_BYTE :
                           (opc == OPC_ST_H) ? SZ_HALF : SZ_WORD;
         end
         default: dec.known = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int NB  = XLEN / 8,
   localparam int LW  = $clog2(NB)
) (
   input  acc_size_e       size,
   input  logic [LW-1:0]   lane,
   input  logic [XLEN-1:0] src,
   output logic [NB-1:0]   be,
   output logic [XLEN-1:0] wdata
);
   for (genvar i = 0; i < NB; i++) begin : g_lane
      localparam int HI = XLEN - 1 - 8 * i;
      localparam logic [LW-1:0] IDX = LW'(i);
      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               wdata[HI -: 8] = src[7:0];
               be[NB-1-i]     = (IDX == lane);
            end
            SZ_HALF: begin
               wdata[HI -: 8] = (i % 2 == 0) ? src[15:8] : src[7:0];
               be[NB-1-i]     = ((IDX >> 1) == (lane >> 1));
            end
            default: begin
               wdata[HI -: 8] = src[HI -: 8];
               be[NB-1-i]     = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
   import lsu_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int NB  = XLEN / 8,
   localparam int LW  = $clog2(NB)
) (
   input  acc_size_e       size,
   input  logic            sext,
   input  logic [LW-1:0]   lane,
   input  logic [XLEN-1:0] rdata,
   output logic [XLEN-1:0] ldata
);
   logic [XLEN-1:0] b_shift;
   logic [XLEN-1:0] h_shift;
   logic [7:0]      b_val;
   logic [15:0]     h_val;

   always_comb begin
      b_shift = rdata >> (8 * (NB - 1 - int'(lane)));
      h_shift = rdata >> (8 * (NB - 2 - int'(lane)));
      b_val   = b_shift[7:0];
      h_val   = h_shift[15:0];
      unique case (size)
         SZ_BYTE: ldata = {{(XLEN-8){sext & b_val[7]}}, b_val};
         SZ_HALF: ldata = {{(XLEN-16){sext & h_val[15]}}, h_val};
         default: ldata = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
   import lsu_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int RIDX_W      = 5,
   parameter bit ALIGN_CHECK = 1'b1,
   localparam int NB         = XLEN / 8,
   localparam int LW         = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic [XLEN-1:0]   ra_val,
   input  logic [XLEN-1:0]   rb_val,
   input  logic [XLEN-1:0]   mem_rdata,
   input  logic              mem_ready,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_excl,
   output logic [XLEN-1:0]   mem_addr,
   output logic [NB-1:0]     mem_be,
   output logic [XLEN-1:0]   mem_wdata,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_idx,
   output logic [XLEN-1:0]   wb_data,
   output logic              fault_illegal,
   output logic              fault_align
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("lsu_core: word accesses are fixed at 32 bits");
   end
   if (RIDX_W != 5) begin : g_bad_ridx
      $error("lsu_core: register index field is 5 bits wide");
   end

   dec_t            dec;
   logic [XLEN-1:0] ea_raw;
   logic [XLEN-1:0] ea;
   logic            misal;
   logic [NB-1:0]   st_be;
   logic [XLEN-1:0] st_wdata;
   logic [XLEN-1:0] ld_data;

   logic            busy_q;
   logic            we_q;
   logic            excl_q;
   logic            sext_q;
   acc_size_e       size_q;
   logic [XLEN-1:0] addr_q;
   logic [NB-1:0]   be_q;
   logic [XLEN-1:0] wdata_q;
   logic [RIDX_W-1:0] dst_q;
   logic            wb_en_q;
   logic [XLEN-1:0] wb_data_q;
   logic            ill_q;
   logic            mis_q;

   lsu_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   assign ea_raw = ra_val + {{(XLEN-16){dec.ofs[15]}}, dec.ofs};

   if (ALIGN_CHECK) begin : g_align_fault
      always_comb begin
         ea = ea_raw;
         unique case (dec.size)
            SZ_HALF: misal = ea_raw[0];
            SZ_WORD: misal = |ea_raw[1:0];
            default: misal = 1'b0;
         endcase
      end
   end else begin : g_align_force
      always_comb begin
         misal = 1'b0;
         ea    = ea_raw;
         unique case (dec.size)
            SZ_HALF: ea[0]   = 1'b0;
            SZ_WORD: ea[1:0] = 2'b00;
            default: ea      = ea_raw;
         endcase
      end
   end

   lsu_store_steer #(.XLEN(XLEN)) u_steer (
      .size  (dec.size),
      .lane  (ea[LW-1:0]),
      .src   (rb_val),
      .be    (st_be),
      .wdata (st_wdata)
   );

   lsu_load_align #(.XLEN(XLEN)) u_align (
      .size  (size_q),
      .sext  (sext_q),
      .lane  (addr_q[LW-1:0]),
      .rdata (mem_rdata),
      .ldata (ld_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         we_q      <= 1'b0;
         excl_q    <= 1'b0;
         sext_q    <= 1'b0;
         size_q    <= SZ_WORD;
         addr_q    <= '0;
         be_q      <= '0;
         wdata_q   <= '0;
         dst_q     <= '0;
         wb_en_q   <= 1'b0;
         wb_data_q <= '0;
         ill_q     <= 1'b0;
         mis_q     <= 1'b0;
      end else begin
         wb_en_q <= 1'b0;
         ill_q   <= 1'b0;
         mis_q   <= 1'b0;
         if (!busy_q) begin
            if (instr_valid) begin
               if (!dec.known) begin
                  ill_q <= 1'b1;
               end else if (misal) begin
                  mis_q <= 1'b1;
               end else begin
                  busy_q  <= 1'b1;
                  we_q    <= dec.is_store;
                  excl_q  <= dec.excl;
                  sext_q  <= dec.sext;
                  size_q  <= dec.size;
                  addr_q  <= ea;
                  be_q    <= st_be;
                  wdata_q <= dec.is_store ? st_wdata : '0;
                  dst_q   <= dec.dst;
               end
            end
         end else if (mem_ready) begin
            busy_q <= 1'b0;
            if (!we_q && (dst_q != '0)) begin
               wb_en_q   <= 1'b1;
               wb_data_q <= ld_data;
            end
         end
      end
   end

   assign busy          = busy_q;
   assign mem_req       = busy_q;
   assign mem_we        = busy_q & we_q;
   assign mem_excl      = busy_q & excl_q;
   assign mem_addr      = addr_q;
   assign mem_be        = be_q;
   assign mem_wdata     = wdata_q;
   assign wb_en         = wb_en_q;
   assign wb_idx        = dst_q;
   assign wb_data       = wb_data_q;
   assign fault_illegal = ill_q;
   assign fault_align   = mis_q;

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
   parameter int XLEN   = 32,
   parameter int RIDX_W = 5,
   localparam int NB    = XLEN / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              mem_ready,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [XLEN-1:0]   mem_addr,
   input logic [NB-1:0]     mem_be,
   input logic [XLEN-1:0]   mem_wdata,
   input logic              wb_en,
   input logic [RIDX_W-1:0] wb_idx,
   input logic              fault_illegal,
   input logic              fault_align
);
   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata));
   // R9
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> !mem_req);
   // R9
   wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> !wb_en);
   // R9
   wb_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_en) |-> $past(mem_req && mem_ready && !mem_we));
   // R6
   wb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_idx != '0);
   // R7
   fault_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_illegal || fault_align) |-> !mem_req);
   // R8
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_illegal, fault_align}));
   // R3
   be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == NB));
   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ready && instr_valid |=> !fault_illegal && !fault_align);
endmodule

bind lsu_core lsu_core_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_lsu_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .instr_valid   (instr_valid),
   .mem_ready     (mem_ready),
   .busy          (busy),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_be        (mem_be),
   .mem_wdata     (mem_wdata),
   .wb_en         (wb_en),
   .wb_idx        (wb_idx),
   .fault_illegal (fault_illegal),
   .fault_align   (fault_align)
);

// File: tb/tb_lsu_core.sv
`timescale 1ns/1ps
module tb_lsu_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] ra_val = '0;
   logic [31:0] rb_val = '0;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        busy, mem_req, mem_we, mem_excl;
   logic [31:0] mem_addr, mem_wdata, wb_data;
   logic [3:0]  mem_be;
   logic        wb_en, fault_illegal, fault_align;
   logic [4:0]  wb_idx;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   lsu_core dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .ra_val(ra_val), .rb_val(rb_val), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_excl(mem_excl),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .fault_illegal(fault_illegal), .fault_align(fault_align)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // 0 illegal, 1 load, 2 store
   function automatic int cls_of(logic [5:0] op);
      case (op)
         6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h1B: return 1;
         6'h35, 6'h36, 6'h37, 6'h33: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int nbytes(logic [5:0] op);
      case (op)
         6'h23, 6'h24, 6'h36: return 1;
         6'h25, 6'h26, 6'h37: return 2;
         default: return 4;
      endcase
   endfunction

   function automatic logic is_signed(logic [5:0] op);
      return (op == 6'h24) || (op == 6'h26);
   endfunction

   function automatic logic [31:0] eff_addr(logic [31:0] ins, logic [31:0] base);
      logic [15:0] imm;
      imm = (cls_of(ins[31:26]) == 2) ? {ins[25:21], ins[10:0]} : ins[15:0];
      return base + {{16{imm[15]}}, imm};
   endfunction

   function automatic logic [3:0] exp_be(int n, logic [1:0] o);
      logic [3:0] m = '0;
      for (int k = 0; k < n; k++) m[3 - (int'(o) + k)] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] exp_wd(int n, logic [31:0] d);
      if (n == 1) return {4{d[7:0]}};
      if (n == 2) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic logic [31:0] exp_ld(int n, logic sx, logic [1:0] o, logic [31:0] rd);
      logic [31:0] s;
      if (n == 1) begin
         s = rd >> (8 * (3 - int'(o)));
         return {{24{sx & s[7]}}, s[7:0]};
      end
      if (n == 2) begin
         s = rd >> (8 * (2 - int'(o)));
         return {{16{sx & s[15]}}, s[15:0]};
      end
      return rd;
   endfunction

   function automatic logic [31:0] mk_ld(logic [5:0] op, logic [4:0] rd, logic [15:0] imm);
      return {op, rd, 5'd1, imm};
   endfunction

   function automatic logic [31:0] mk_st(logic [5:0] op, logic [15:0] imm);
      return {op, imm[15:11], 5'd1, 5'd2, imm[10:0]};
   endfunction

   task automatic run(logic [31:0] ins, logic [31:0] ra, logic [31:0] rb,
                      logic [31:0] rdat, int wait_n, bit poke);
      logic [5:0]  op = ins[31:26];
      int          c  = cls_of(op);
      int          n  = nbytes(op);
      logic [31:0] ea = eff_addr(ins, ra);
      bit          mis = (n == 2 && ea[0]) || (n == 4 && ea[1:0] != 2'b00);
      bit          wb;
      @(negedge clk);
      instr = ins; ra_val = ra; rb_val = rb; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      if (c == 0) begin
         chk("R7 illegal flag", {31'd0, fault_illegal}, 32'd1);
         chk("R7 no request", {31'd0, mem_req}, 32'd0);
         @(negedge clk);
         chk("R7 one-cycle pulse", {31'd0, fault_illegal}, 32'd0);
         return;
      end
      if (mis) begin
         chk("R8 align flag", {31'd0, fault_align}, 32'd1);
         chk("R8 no request", {31'd0, mem_req}, 32'd0);
         @(negedge clk);
         chk("R8 one-cycle pulse", {31'd0, fault_align}, 32'd0);
         return;
      end
      chk(c == 1 ? "R1 load address" : "R2 store address", mem_addr, ea);
      chk("R9 request up", {31'd0, mem_req}, 32'd1);
      chk("R9 write flag", {31'd0, mem_we}, {31'd0, c == 2});
      chk("R5 exclusive mark", {31'd0, mem_excl}, {31'd0, op == 6'h1B || op == 6'h33});
      chk(c == 2 ? "R3 store enables" : "R4 load enables", {28'd0, mem_be}, {28'd0, exp_be(n, ea[1:0])});
      if (c == 2) chk("R3 store data", mem_wdata, exp_wd(n, rb));
      for (int w = 0; w < wait_n; w++) begin
         if (poke && w == 0) begin
            instr = 32'h0; instr_valid = 1'b1;
         end
         @(negedge clk);
         instr_valid = 1'b0;
         chk("R9 request held", {31'd0, mem_req}, 32'd1);
         chk("R9 address held", mem_addr, ea);
         if (poke && w == 0) chk("R10 busy ignores input", {30'd0, fault_illegal, fault_align}, 32'd0);
      end
      mem_ready = 1'b1; mem_rdata = rdat;
      @(negedge clk);
      mem_ready = 1'b0;
      chk("R9 request drops", {31'd0, mem_req}, 32'd0);
      wb = (c == 1) && (ins[25:21] != 5'd0);
      chk(wb || c == 2 ? "R9 write-back strobe" : "R6 no write to r0", {31'd0, wb_en}, {31'd0, wb});
      if (wb) begin
         chk("R4 load result", wb_data, exp_ld(n, is_signed(op), ea[1:0], rdat));
         chk("R1 destination index", {27'd0, wb_idx}, {27'd0, ins[25:21]});
      end
      @(negedge clk);
      chk("R9 strobe one cycle", {31'd0, wb_en}, 32'd0);
   endtask

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [5:0] ops [11] = '{6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h1B,
                               6'h35, 6'h36, 6'h37, 6'h33};
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk("R11 reset busy", {31'd0, busy}, 32'd0);
      chk("R11 reset request", {30'd0, mem_req, mem_we}, 32'd0);
      chk("R11 reset strobes", {29'd0, wb_en, fault_illegal, fault_align}, 32'd0);
      rst_n = 1'b1;

      // directed corner cases
      run(mk_ld(6'h24, 5'd3, 16'd1), 32'h1000, 0, 32'h11F23344, 0, 0);     // R4 byte signed
      run(mk_ld(6'h23, 5'd3, 16'd1), 32'h1000, 0, 32'h11F23344, 1, 0);     // R4 byte zero
      run(mk_ld(6'h26, 5'd4, 16'd2), 32'h1000, 0, 32'h12348001, 2, 0);     // R4 half signed
      run(mk_ld(6'h25, 5'd4, 16'hFFFE), 32'h1004, 0, 32'h12348001, 0, 0);  // R1 negative offset
      run(mk_ld(6'h21, 5'd0, 16'd0), 32'h2000, 0, 32'hDEADBEEF, 1, 0);     // R6
      run(mk_ld(6'h1B, 5'd7, 16'd4), 32'h3000, 0, 32'hCAFEF00D, 2, 1);     // R5 R10
      run(mk_st(6'h36, 16'hFFFF), 32'h2000, 32'h000000A5, 0, 0, 0);        // R2 R3
      run(mk_st(6'h37, 16'h0800), 32'h2000, 32'h0000BEEF, 0, 1, 0);        // R2 upper field
      run(mk_st(6'h33, 16'h0004), 32'h2000, 32'h01234567, 0, 3, 1);        // R5
      run(mk_ld(6'h25, 5'd1, 16'd3), 32'h1000, 0, 0, 0, 0);                // R8 half odd
      run(mk_st(6'h35, 16'd2), 32'h1000, 0, 0, 0, 0);                      // R8 word
      run({6'h20, 26'h0}, 0, 0, 0, 0, 0);                                  // R7
      run({6'h3F, 26'h155}, 0, 0, 0, 0, 0);                                // R7

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ins, ra;
         logic [15:0] imm;
         logic [1:0]  lo;
         logic [5:0]  op;
         if ($urandom_range(0, 9) == 0) op = 6'($urandom_range(0, 63));
         else op = ops[$urandom_range(0, 10)];
         imm = 16'($urandom);
         if (cls_of(op) == 2) ins = mk_st(op, imm);
         else ins = mk_ld(op, 5'($urandom), imm);
         lo = ($urandom_range(0, 4) == 0) ? 2'($urandom) :
              (nbytes(op) == 1) ? 2'($urandom) : (nbytes(op) == 2) ? {1'($urandom), 1'b0} : 2'b00;
         ra = ($urandom & 32'hFFFF_FFFC) | {30'd0, lo - imm[1:0]};
         run(ins, ra, $urandom, $urandom, $urandom_range(0, 3), $urandom_range(0, 3) == 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule